// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit modified virtual address into a physical mapping when the translation cache misses. It reads a first-level descriptor from a table whose base address it is given. When that descriptor points to a second-level table, it reads a second-level descriptor as well. All reads go through a single request/response memory port, and that port can report an error.

A walk ends in one of two ways:
- A mapping: virtual base, physical base, size code, domain, access-permission bits and a section/page flag. The block also pulses an insert strobe so the translation cache can store the mapping.
- A packed fault status word.

Checking permissions against the domain settings is left to the consumer, and so is performing the data access.

The block handles three mapping sizes: 1 MB sections, 64 KB large pages and 4 KB small pages. Each failure cause has its own fault code.

Top module: `pt_walker`

## Requirements
- R1: When a walk is accepted with `tbase_i[1:0]` not zero, no memory request is issued. `done_o` and `fault_o` rise one cycle after acceptance, and the fault code in `fault_word_o[3:0]` is 1.
- R2: The first fetch address is `tbase_i + (va[31:20] << 2)`.
- R3: A memory error on the first fetch gives code 12. A memory error on the second fetch gives code 14. Both report domain 0.
- R4: First-level type bits [1:0]: 0 gives code 5 with domain bits [8:5] of the descriptor; 2 is a section; 1 points to a second-level table; 3 gives code 12 with domain 0.
- R5: A section result carries virtual base `va & 0xFFF00000`, physical base `desc & 0xFFF00000`, size code 0, domain from desc[8:5], permissions from desc[11:10], and section flag 1.
- R6: The second fetch address is `(l1desc & 0xFFFFFC00) + (va[19:12] << 2)`.
- R7: Second-level type bits [1:0]: 0 gives code 7 with the first-level domain; 3 gives code 14 with domain 0.
- R8: Second-level type 1 is a 64 KB page (size code 1, bases masked by 0xFFFF0000). Type 2 is a 4 KB page (size code 2, bases masked by 0xFFFFF000). Both take permissions from second-level bits [5:4] and the domain from the first-level descriptor, and set the section flag to 0.
- R9: The fault word places the code in bits [3:0], the domain in bits [7:4] and the request's write flag in bit 11. All other bits are zero.
- R10: Handshake rules:
  - While no response arrives, `mem_req_o` stays high and `mem_addr_o` holds steady.
  - `done_o` is a one-cycle pulse.
  - `ins_valid_o` pulses only with a successful `done_o`.
  - `start_i` is ignored while `busy_o` is high, and does not alter the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| va_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | Access is a write (goes into the fault word) |
| tbase_i | input | 32 | First-level table base address |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rsp_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Read response carries an error |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Finished walk faulted |
| fault_word_o | output | 12 | Packed fault status |
| ins_valid_o | output | 1 | Insert strobe to the translation cache |
| map_vbase_o | output | 32 | Mapping virtual base |
| map_pbase_o | output | 32 | Mapping physical base |
| map_size_o | output | 2 | 0: 1 MB, 1: 64 KB, 2: 4 KB |
| map_domain_o | output | 4 | Mapping domain |
| map_ap_o | output | 2 | Access permission bits |
| map_sect_o | output | 1 | 1 for a section mapping |

## Verification
The bench goes after the following corner cases:
- A misaligned table base. A design that issued a fetch first would show a stray request and a late fault.
- Both descriptor type 3 values. A design that decoded these as mappings would raise a false insert, and one that mixed up the levels would report code 12 where 14 is due.
- Memory errors at each level.
- Second-level translation faults, which must carry the domain learned at the first level. A design that dropped that domain would show zeros in bits [7:4].
- Responses delayed by several cycles, with new start pulses arriving mid-walk. A design that re-accepted start would corrupt the address or the result.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned FW_W   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_L1,
    ST_FETCH_L2,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'd0,
    SZ_LARGE   = 2'd1,
    SZ_SMALL   = 2'd2
  } map_size_e;

  typedef enum logic [1:0] {
    L1K_XLAT,
    L1K_SECTION,
    L1K_TABLE,
    L1K_BAD
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2K_XLAT,
    L2K_LARGE,
    L2K_SMALL,
    L2K_BAD
  } l2_kind_e;

  localparam logic [3:0] FC_ALIGN   = 4'd1;
  localparam logic [3:0] FC_XLAT_L1 = 4'd5;
  localparam logic [3:0] FC_XLAT_L2 = 4'd7;
  localparam logic [3:0] FC_EXT_L1  = 4'd12;
  localparam logic [3:0] FC_EXT_L2  = 4'd14;

  typedef struct packed {
    logic [ADDR_W-1:0] vbase;
    logic [ADDR_W-1:0] pbase;
    map_size_e         size;
    logic [3:0]        dom;
    logic [1:0]        ap;
    logic              sect;
  } map_t;

  function automatic logic [ADDR_W-1:0] l1_fetch_addr(
      input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] va);
    return base + {18'd0, va[31:20], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] l2_fetch_addr(
      input logic [ADDR_W-1:0] l1d, input logic [ADDR_W-1:0] va);
    return (l1d & 32'hFFFF_FC00) + {22'd0, va[19:12], 2'b00};
  endfunction

  function automatic logic [FW_W-1:0] pack_fault(
      input logic [3:0] code, input logic [3:0] dom, input logic wr);
    return {wr, 3'b000, dom, code};
  endfunction

endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
  import pt_walker_pkg::*;
(
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] va_i,
  output l1_kind_e          kind_o,
  output logic [3:0]        dom_o,
  output map_t              sect_map_o,
  output logic [ADDR_W-1:0] l2_addr_o
);
  always_comb begin
    unique case (desc_i[1:0])
      2'd0:    kind_o = L1K_XLAT;
      2'd1:    kind_o = L1K_TABLE;
      2'd2:    kind_o = L1K_SECTION;
      default: kind_o = L1K_BAD;
    endcase
  end

  assign dom_o = desc_i[8:5];
  assign l2_addr_o = l2_fetch_addr(desc_i, va_i);

  always_comb begin
    sect_map_o.vbase = va_i & 32'hFFF0_0000;
    sect_map_o.pbase = desc_i & 32'hFFF0_0000;
    sect_map_o.size  = SZ_SECTION;
    sect_map_o.dom   = desc_i[8:5];
    sect_map_o.ap    = desc_i[11:10];
    sect_map_o.sect  = 1'b1;
  end
endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
  import pt_walker_pkg::*;
(
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [3:0]        dom_i,
  output l2_kind_e          kind_o,
  output map_t              page_map_o
);
  logic [ADDR_W-1:0] mask;

  always_comb begin
    unique case (desc_i[1:0])
      2'd0:    kind_o = L2K_XLAT;
      2'd1:    kind_o = L2K_LARGE;
      2'd2:    kind_o = L2K_SMALL;
      default: kind_o = L2K_BAD;
    endcase
  end

  assign mask = (desc_i[1:0] == 2'd1) ? 32'hFFFF_0000 : 32'hFFFF_F000;

  always_comb begin
    page_map_o.vbase = va_i & mask;
    page_map_o.pbase = desc_i & mask;
    page_map_o.size  = (desc_i[1:0] == 2'd1) ? SZ_LARGE : SZ_SMALL;
    page_map_o.dom   = dom_i;
    page_map_o.ap    = desc_i[5:4];
    page_map_o.sect  = 1'b0;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       va_i,
  input  logic              write_i,
  input  logic [31:0]       tbase_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rsp_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [11:0]       fault_word_o,
  output logic              ins_valid_o,
  output logic [31:0]       map_vbase_o,
  output logic [31:0]       map_pbase_o,
  output logic [1:0]        map_size_o,
  output logic [3:0]        map_domain_o,
  output logic [1:0]        map_ap_o,
  output logic              map_sect_o
);
  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        dom_q;
  map_t              map_q;
  logic [FW_W-1:0]   fword_q;

  // named events for the checker
  logic walk_accept;
  logic l1_rsp;
  logic l2_rsp;
  logic base_misaligned;

  assign walk_accept     = start_i && (state_q == ST_IDLE);
  assign l1_rsp          = (state_q == ST_FETCH_L1) && mem_rsp_i;
  assign l2_rsp          = (state_q == ST_FETCH_L2) && mem_rsp_i;
  assign base_misaligned = tbase_i[1:0] != 2'b00;

  l1_kind_e          l1_kind;
  logic [3:0]        l1_dom;
  map_t              l1_map;
  logic [ADDR_W-1:0] l1_next_addr;
  l2_kind_e          l2_kind;
  map_t              l2_map;

  pt_l1_decode u_l1 (
    .desc_i     (mem_rdata_i),
    .va_i       (va_q),
    .kind_o     (l1_kind),
    .dom_o      (l1_dom),
    .sect_map_o (l1_map),
    .l2_addr_o  (l1_next_addr)
  );

  pt_l2_decode u_l2 (
    .desc_i     (mem_rdata_i),
    .va_i       (va_q),
    .dom_i      (dom_q),
    .kind_o     (l2_kind),
    .page_map_o (l2_map)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      dom_q   <= '0;
      map_q   <= '0;
      fword_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (walk_accept) begin
            va_q <= va_i;
            wr_q <= write_i;
            if (base_misaligned) begin
              fword_q <= pack_fault(FC_ALIGN, 4'd0, write_i);
              state_q <= ST_FAULT;
            end else begin
              addr_q  <= l1_fetch_addr(tbase_i, va_i);
              state_q <= ST_FETCH_L1;
            end
          end
        end
        ST_FETCH_L1: begin
          if (l1_rsp) begin
            if (mem_err_i) begin
              fword_q <= pack_fault(FC_EXT_L1, 4'd0, wr_q);
              state_q <= ST_FAULT;
            end else begin
              unique case (l1_kind)
                L1K_XLAT: begin
                  fword_q <= pack_fault(FC_XLAT_L1, l1_dom, wr_q);
                  state_q <= ST_FAULT;
                end
                L1K_SECTION: begin
                  map_q   <= l1_map;
                  fword_q <= '0;
                  state_q <= ST_DONE;
                end
                L1K_TABLE: begin
                  addr_q  <= l1_next_addr;
                  dom_q   <= l1_dom;
                  state_q <= ST_FETCH_L2;
                end
                default: begin
                  fword_q <= pack_fault(FC_EXT_L1, 4'd0, wr_q);
                  state_q <= ST_FAULT;
                end
              endcase
            end
          end
        end
        ST_FETCH_L2: begin
          if (l2_rsp) begin
            if (mem_err_i) begin
              fword_q <= pack_fault(FC_EXT_L2, 4'd0, wr_q);
              state_q <= ST_FAULT;
            end else begin
              unique case (l2_kind)
                L2K_XLAT: begin
                  fword_q <= pack_fault(FC_XLAT_L2, dom_q, wr_q);
                  state_q <= ST_FAULT;
                end
                L2K_LARGE, L2K_SMALL: begin
                  map_q   <= l2_map;
                  fword_q <= '0;
                  state_q <= ST_DONE;
                end
                default: begin
                  fword_q <= pack_fault(FC_EXT_L2, 4'd0, wr_q);
                  state_q <= ST_FAULT;
                end
              endcase
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != ST_IDLE;
  assign mem_req_o    = (state_q == ST_FETCH_L1) || (state_q == ST_FETCH_L2);
  assign mem_addr_o   = addr_q;
  assign done_o       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault_o      = state_q == ST_FAULT;
  assign ins_valid_o  = state_q == ST_DONE;
  assign fault_word_o = fword_q;
  assign map_vbase_o  = map_q.vbase;
  assign map_pbase_o  = map_q.pbase;
  assign map_size_o   = map_q.size;
  assign map_domain_o = map_q.dom;
  assign map_ap_o     = map_q.ap;
  assign map_sect_o   = map_q.sect;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] va_i,
  input logic [31:0] tbase_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rsp_i,
  input logic        done_o,
  input logic        fault_o,
  input logic [11:0] fault_word_o,
  input logic        ins_valid_o,
  input logic        walk_accept
);
  p_align_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept && (tbase_i[1:0] != 2'b00) |=>
      done_o && fault_o && !mem_req_o && (fault_word_o[3:0] == 4'd1));

  p_l1_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept && (tbase_i[1:0] == 2'b00) |=>
      mem_req_o && (mem_addr_o == $past(tbase_i) + {18'd0, $past(va_i[31:20]), 2'b00}));

  p_ext_dom_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && ((fault_word_o[3:0] == 4'd12) || (fault_word_o[3:0] == 4'd14)) |->
      fault_word_o[7:4] == 4'd0);

  p_word_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_word_o[10:8] == 3'b000);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_insert_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o |-> done_o && !fault_o);

  p_fault_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o && busy_o);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        write_i = 1'b0;
  logic [31:0] tbase_i = '0;
  logic        busy_o, mem_req_o, mem_rsp_i, mem_err_i;
  logic [31:0] mem_addr_o, mem_rdata_i;
  logic        done_o, fault_o, ins_valid_o, map_sect_o;
  logic [11:0] fault_word_o;
  logic [31:0] map_vbase_o, map_pbase_o;
  logic [1:0]  map_size_o, map_ap_o;
  logic [3:0]  map_domain_o;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  int unsigned cycles = 0;

  always #5 clk = ~clk;

  initial begin
    mem_rsp_i = 1'b0;
    mem_err_i = 1'b0;
    mem_rdata_i = '0;
  end

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .write_i(write_i),
    .tbase_i(tbase_i), .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i),
    .done_o(done_o), .fault_o(fault_o), .fault_word_o(fault_word_o),
    .ins_valid_o(ins_valid_o), .map_vbase_o(map_vbase_o), .map_pbase_o(map_pbase_o),
    .map_size_o(map_size_o), .map_domain_o(map_domain_o), .map_ap_o(map_ap_o),
    .map_sect_o(map_sect_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] fw(input int code, input logic [3:0] dom, input logic w);
    logic [11:0] r;
    r = 12'(code);
    r = r | (12'(dom) << 4);
    r = r | (12'(w) << 11);
    return r;
  endfunction

  // one walk; dly = response latency in cycles for each fetch
  task automatic run_walk(input logic [31:0] va, input logic w, input logic [31:0] base,
                          input logic [31:0] d1, input logic e1,
                          input logic [31:0] d2, input logic e2, input int dly);
    bit          exp_fault;
    int          exp_code;
    logic [3:0]  exp_dom;
    int          exp_fetches;
    logic [31:0] a1, a2, m, ev, ep;
    logic [1:0]  es, eap;
    logic        esect;
    int          lvl, cnt, guard;
    bit          seen;
    a1 = base + ({20'd0, va[31:20]} << 2);
    a2 = (d1 & 32'hFFFF_FC00) + ({24'd0, va[19:12]} << 2);
    exp_fault = 1; exp_code = 0; exp_dom = 0; exp_fetches = 0;
    ev = 0; ep = 0; es = 0; eap = 0; esect = 0;
    if (base[1:0] != 2'b00) exp_code = 1;
    else begin
      exp_fetches = 1;
      if (e1) exp_code = 12;
      else if (d1[1:0] == 2'd0) begin exp_code = 5; exp_dom = d1[8:5]; end
      else if (d1[1:0] == 2'd3) exp_code = 12;
      else if (d1[1:0] == 2'd2) begin
        exp_fault = 0; ev = va & 32'hFFF0_0000; ep = d1 & 32'hFFF0_0000;
        es = 0; exp_dom = d1[8:5]; eap = d1[11:10]; esect = 1;
      end else begin
        exp_fetches = 2;
        if (e2) exp_code = 14;
        else if (d2[1:0] == 2'd0) begin exp_code = 7; exp_dom = d1[8:5]; end
        else if (d2[1:0] == 2'd3) exp_code = 14;
        else begin
          exp_fault = 0;
          m = (d2[1:0] == 2'd1) ? 32'hFFFF_0000 : 32'hFFFF_F000;
          ev = va & m; ep = d2 & m; es = (d2[1:0] == 2'd1) ? 2'd1 : 2'd2;
          exp_dom = d1[8:5]; eap = d2[5:4]; esect = 0;
        end
      end
    end

    @(negedge clk);
    start_i = 1; va_i = va; write_i = w; tbase_i = base;
    @(negedge clk);
    start_i = 0;
    lvl = 0; cnt = 0; seen = 0; guard = 0;
    while (!done_o && guard < 60) begin
      if (mem_req_o) begin
        if (!seen) begin
          if (lvl == 0) chk(mem_addr_o == a1, "R2 first fetch address", mem_addr_o, a1);
          else          chk(mem_addr_o == a2, "R6 second fetch address", mem_addr_o, a2);
          seen = 1;
        end
        if (cnt >= dly) begin
          mem_rsp_i = 1;
          mem_err_i = (lvl == 0) ? e1 : e2;
          mem_rdata_i = (lvl == 0) ? d1 : d2;
          lvl++; cnt = 0; seen = 0;
        end else begin
          cnt++;
          start_i = 1; va_i = ~va; tbase_i = base ^ 32'h0000_1000; // R10 ignored
        end
      end
      @(negedge clk);
      mem_rsp_i = 0; mem_err_i = 0; mem_rdata_i = $urandom; start_i = 0;
      va_i = va; tbase_i = base;
      guard++;
    end
    chk(done_o == 1'b1, "R10 walk finished", {31'd0, done_o}, 32'd1);
    chk(lvl == exp_fetches, "R1 fetch count", lvl, exp_fetches);
    chk(fault_o == exp_fault, "R10 fault flag", {31'd0, fault_o}, {31'd0, exp_fault});
    chk(ins_valid_o == !exp_fault, "R10 insert strobe", {31'd0, ins_valid_o}, {31'd0, !exp_fault});
    if (exp_fault) begin
      case (exp_code)
        1:  chk(fault_word_o == fw(1, 0, w), "R1 R9 align fault word", fault_word_o, fw(1, 0, w));
        5:  chk(fault_word_o == fw(5, exp_dom, w), "R4 R9 l1 translation fault", fault_word_o, fw(5, exp_dom, w));
        7:  chk(fault_word_o == fw(7, exp_dom, w), "R7 R9 l2 translation fault", fault_word_o, fw(7, exp_dom, w));
        12: chk(fault_word_o == fw(12, 0, w), "R3 R4 l1 external fault", fault_word_o, fw(12, 0, w));
        default: chk(fault_word_o == fw(14, 0, w), "R3 R7 l2 external fault", fault_word_o, fw(14, 0, w));
      endcase
    end else if (esect) begin
      chk(map_vbase_o == ev, "R5 section vbase", map_vbase_o, ev);
      chk(map_pbase_o == ep, "R5 section pbase", map_pbase_o, ep);
      chk({map_size_o, map_ap_o, map_domain_o, map_sect_o} == {es, eap, exp_dom, 1'b1},
          "R5 section attrs", {23'd0, map_size_o, map_ap_o, map_domain_o, map_sect_o},
          {23'd0, es, eap, exp_dom, 1'b1});
    end else begin
      chk(map_vbase_o == ev, "R8 page vbase", map_vbase_o, ev);
      chk(map_pbase_o == ep, "R8 page pbase", map_pbase_o, ep);
      chk({map_size_o, map_ap_o, map_domain_o, map_sect_o} == {es, eap, exp_dom, 1'b0},
          "R8 page attrs", {23'd0, map_size_o, map_ap_o, map_domain_o, map_sect_o},
          {23'd0, es, eap, exp_dom, 1'b0});
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 done is one pulse", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] rv;
    rv = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !ins_valid_o, "R10 reset state",
        {28'd0, busy_o, done_o, mem_req_o, ins_valid_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    run_walk(32'h1234_5678, 1, 32'h0000_4002, 32'h0, 0, 32'h0, 0, 0);           // R1
    run_walk(32'h0010_0020, 0, 32'h0000_0000, 32'h0010_0C02 | (4'd3 << 5), 0, 0, 0, 0); // R5
    run_walk(32'hFFF4_5ABC, 1, 32'h8000_0000, 32'h0000_01E0, 0, 0, 0, 2);        // R4 code 5
    run_walk(32'h0200_0000, 0, 32'h0001_0000, 32'h0000_0003, 0, 0, 0, 1);        // R4 type 3
    run_walk(32'h0300_1000, 1, 32'h0001_0000, 32'h0, 1, 0, 0, 3);                // R3 l1 err
    run_walk(32'h0045_6789, 0, 32'h0002_0000, 32'hABCD_E4A1, 0, 32'h1234_5631, 0, 1); // R8 64K
    run_walk(32'h0045_6789, 1, 32'h0002_0000, 32'hABCD_E4A1, 0, 32'h1234_5622, 0, 0); // R8 4K
    run_walk(32'h00FF_F000, 1, 32'h0002_0000, 32'h0000_7C41, 0, 32'h0000_0000, 0, 2); // R7 code 7
    run_walk(32'h00FF_F000, 0, 32'h0002_0000, 32'h0000_7C41, 0, 32'h0000_0003, 0, 0); // R7 type 3
    run_walk(32'h00FF_F000, 1, 32'h0002_0000, 32'h0000_7C41, 0, 32'h0, 1, 4);    // R3 l2 err
    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, base, d1, d2;
      logic w, e1, e2;
      va = $urandom; w = 1'($urandom);
      base = $urandom & 32'hFFFF_FFFC;
      if (($urandom % 16) == 0) base[1:0] = 2'($urandom % 3 + 1);
      d1 = $urandom; d2 = $urandom;
      e1 = (($urandom % 10) == 0); e2 = (($urandom % 10) == 0);
      if (($urandom % 3) == 0) d1[1:0] = 2'd1;
      run_walk(va, w, base, d1, e1, d2, e2, int'($urandom % 4));
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule